// File: doc/BRIEF.md
# Compare-Match Timer Channel

This block is one channel of a system timer. Software sets it up through a small synchronous register port. It loads a compare value and picks one of two counting modes. It then starts and stops the channel through two separate trigger registers. A tick input paces the counter. The interrupt output gives one clock-wide pulse for each timer event.

In interval mode the counter is loaded with the compare value and counts down once per tick. On the tick that finds it at zero, the counter reloads and the channel pulses the interrupt. A compare value of N−1 therefore gives an event every N ticks, with no software involvement. In free-running mode the counter is cleared and counts up, wrapping at its width. The channel pulses the interrupt on the tick that brings the counter to the compare value. With the compare value at zero the counter serves as a monotonic time base. With a delta loaded, software gets a single event by halting the channel from its handler.

Compare and mode writes land in a holding copy. The running channel works from a snapshot that is taken at each start. The controller has three states:

- IDLE: the channel is stopped.
- INTERVAL: the channel is counting down.
- FREE: the channel is counting up.

The transitions are:

- A start write moves from any state to INTERVAL or FREE, according to the held mode bit. A start while running restarts the channel.
- A stop write moves from any state to IDLE.
- With neither write, the controller stays in its state.

Top module: `cmt_channel`

## Requirements
- R1: After reset the compare, counter, status and control registers all read zero, and the interrupt output is low.
- R2: Offset 0x00 holds a 32-bit read/write compare value. Offset 0x20 holds control, where bit 1 selects the mode (0 = interval, 1 = free-running). The other control bits read as zero.
- R3: Writing a word with bit 0 set to offset 0x14 starts the channel, and bit 0 of offset 0x10 then reads 1 from the next cycle. Writing a word with bit 0 set to offset 0x18 stops it, and that status bit then reads 0. A trigger write with bit 0 clear has no effect.
- R4: In interval mode a start loads the counter with the compare value. Each tick decrements it. A tick that finds the counter at zero reloads it and raises the interrupt, so a compare value of N−1 gives an interrupt every N ticks.
- R5: In free-running mode a start clears the counter to zero. Each tick adds one, modulo 2^32. An interrupt is raised on the tick that makes the counter equal to the compare value, so the first event comes exactly that many ticks after the start. Counting continues after the event.
- R6: In free-running mode with a compare value of zero, the counter runs continuously and no interrupt is raised before it wraps.
- R7: The interrupt is high for exactly one clock, in the cycle after the clock edge at which the event tick is sampled. It is never raised while the channel is stopped.
- R8: Compare or control writes made while the channel runs are readable at once, but they change counting only from the next start.
- R9: While stopped, ticks have no effect and the counter holds its last value, which stays readable at offset 0x04.
- R10: The trigger offsets 0x14 and 0x18 read zero. Writes to the counter (0x04) and status (0x10) offsets are ignored.
- R11: Compare values up to 0xFFFFFFFF are handled in interval mode. A small value such as 0xF in free-running mode fires after exactly 15 ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| tick | input | 1 | Count-enable, one count per cycle it is high |
| irq | output | 1 | Single-cycle event pulse |

## Verification
Interval mode is driven with a short period over several periods, which separates an off-by-one in the reload from a correct period of N ticks. Free-running mode is driven with a small delta, with a zero compare value and with 0xF. These three cases separate a match on the counter's new value from a match on its old value, and show that zero gives no early event. A mid-run change of compare and mode shows whether the snapshot isolates the running channel. Stopped-state ticks and writes to the read-only offsets show whether the counter is truly frozen and protected.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
    localparam int ADDR_W = 6;

    localparam logic [ADDR_W-1:0] OFS_CMP  = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_CNT  = 6'h04;
    localparam logic [ADDR_W-1:0] OFS_STAT = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_GO   = 6'h14;
    localparam logic [ADDR_W-1:0] OFS_HALT = 6'h18;
    localparam logic [ADDR_W-1:0] OFS_MODE = 6'h20;

    localparam int MODE_BIT = 1;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_INTERVAL = 2'd1,
        ST_FREE     = 2'd2
    } ctrl_state_t;
endpackage

// File: rtl/cmt_regbank.sv
module cmt_regbank
    import cmt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic              running,
    output logic [CNT_W-1:0]  rdata,
    output logic [CNT_W-1:0]  cmp_q,
    output logic              mode_q,
    output logic              go_pulse,
    output logic              halt_pulse
);
    logic wr_hit;

    assign wr_hit     = sel && wr;
    assign go_pulse   = wr_hit && (addr == OFS_GO)   && wdata[0];
    assign halt_pulse = wr_hit && (addr == OFS_HALT) && wdata[0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q  <= '0;
            mode_q <= 1'b0;
        end else if (wr_hit) begin
            if (addr == OFS_CMP)  cmp_q  <= wdata;
            if (addr == OFS_MODE) mode_q <= wdata[MODE_BIT];
        end
    end

    always_comb begin
        rdata = '0;
        if (sel && !wr) begin
            case (addr)
                OFS_CMP:  rdata = cmp_q;
                OFS_CNT:  rdata = cnt_val;
                OFS_STAT: rdata = {{(CNT_W-1){1'b0}}, running};
                OFS_MODE: rdata = {{(CNT_W-2){1'b0}}, mode_q, 1'b0};
                default:  rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/cmt_ctrl.sv
module cmt_ctrl
    import cmt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             halt,
    input  logic             tick,
    input  logic [CNT_W-1:0] cmp_q,
    input  logic             mode_q,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cmp_act,
    output logic             running,
    output logic             free_mode,
    output logic             irq
);
    ctrl_state_t state, state_nx;
    logic [CNT_W-1:0] cnt_inc;

    assign cnt_inc   = cnt + 1'b1;
    assign running   = (state != ST_IDLE);
    assign free_mode = (state == ST_FREE);

    always_comb begin
        state_nx = state;
        if (halt)
            state_nx = ST_IDLE;
        else if (go)
            state_nx = mode_q ? ST_FREE : ST_INTERVAL;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            cmp_act <= '0;
            irq     <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (halt) begin
                cnt <= cnt;
            end else if (go) begin
                cmp_act <= cmp_q;
                cnt     <= mode_q ? '0 : cmp_q;
            end else if (tick) begin
                unique case (state)
                    ST_IDLE: cnt <= cnt;
                    ST_INTERVAL: begin
                        if (cnt == '0) begin
                            cnt <= cmp_act;
                            irq <= 1'b1;
                        end else begin
                            cnt <= cnt - 1'b1;
                        end
                    end
                    ST_FREE: begin
                        cnt <= cnt_inc;
                        if (cnt_inc == cmp_act) irq <= 1'b1;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/cmt_channel.sv
module cmt_channel
    import cmt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    input  logic              tick,
    output logic              irq
);
    logic [CNT_W-1:0] cnt_val;
    logic [CNT_W-1:0] cmp_q;
    logic [CNT_W-1:0] cmp_act;
    logic             mode_q;
    logic             go_pulse;
    logic             halt_pulse;
    logic             running;
    logic             free_mode;

    cmt_regbank #(.CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel        (bus_sel),
        .wr         (bus_wr),
        .addr       (bus_addr),
        .wdata      (bus_wdata),
        .cnt_val    (cnt_val),
        .running    (running),
        .rdata      (bus_rdata),
        .cmp_q      (cmp_q),
        .mode_q     (mode_q),
        .go_pulse   (go_pulse),
        .halt_pulse (halt_pulse)
    );

    cmt_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go_pulse),
        .halt      (halt_pulse),
        .tick      (tick),
        .cmp_q     (cmp_q),
        .mode_q    (mode_q),
        .cnt       (cnt_val),
        .cmp_act   (cmp_act),
        .running   (running),
        .free_mode (free_mode),
        .irq       (irq)
    );
endmodule

// File: rtl/cmt_checker.sv
module cmt_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             go,
    input logic             halt,
    input logic             tick,
    input logic             running,
    input logic             free_mode,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] cmp_act,
    input logic             irq
);
    p_go_runs_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !halt) |=> running);

    p_halt_idles_r3: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> !running);

    p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && running && !free_mode) |-> (cnt == cmp_act));

    p_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && free_mode) |-> (cnt == cmp_act));

    p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (free_mode && tick && !go && !halt) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

    p_irq_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(running && tick && !go && !halt));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !go) |=> $stable(cnt));
endmodule

bind cmt_channel cmt_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go_pulse),
    .halt      (halt_pulse),
    .tick      (tick),
    .running   (running),
    .free_mode (free_mode),
    .cnt       (cnt_val),
    .cmp_act   (cmp_act),
    .irq       (irq)
);

// File: tb/sim_cmt_channel.sv
module sim_cmt_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tick = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [5:0] A_CMP = 6'h00, A_CNT = 6'h04, A_STAT = 6'h10,
                           A_GO = 6'h14, A_HALT = 6'h18, A_MODE = 6'h20;

    always #5 clk = ~clk;

    cmt_channel u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick(tick), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic do_tick(output logic fired);
        tick = 1'b1;
        @(posedge clk); @(negedge clk);
        tick = 1'b0;
        fired = irq;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 irq", {31'b0, irq}, 32'd0);
        rd(A_CMP, v);  chk("R1 cmp", v, 32'd0);
        rd(A_CNT, v);  chk("R1 cnt", v, 32'd0);
        rd(A_STAT, v); chk("R1 status", v, 32'd0);
        rd(A_MODE, v); chk("R1 control", v, 32'd0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        wr(A_CMP, 32'hA5A5_5A5A); rd(A_CMP, v); chk("R2 cmp rw", v, 32'hA5A5_5A5A);
        wr(A_MODE, 32'hFF);       rd(A_MODE, v); chk("R2 ctl bit1 only", v, 32'h2);
        wr(A_MODE, 32'h0);        rd(A_MODE, v); chk("R2 ctl clear", v, 32'h0);
    endtask

    task automatic t_trigger();
        logic [31:0] v;
        wr(A_GO, 32'h0);   rd(A_STAT, v); chk("R3 start bit0 clear", v, 32'd0);
        wr(A_GO, 32'h1);   rd(A_STAT, v); chk("R3 start", v, 32'd1);
        wr(A_HALT, 32'h0); rd(A_STAT, v); chk("R3 stop bit0 clear", v, 32'd1);
        wr(A_HALT, 32'h1); rd(A_STAT, v); chk("R3 stop", v, 32'd0);
    endtask

    task automatic t_interval();
        logic [31:0] v;
        logic f;
        wr(A_CMP, 32'd3); wr(A_MODE, 32'd0); wr(A_GO, 32'd1);
        rd(A_CNT, v); chk("R4 load on start", v, 32'd3);
        for (int i = 1; i <= 12; i++) begin
            do_tick(f);
            chk("R4 period 4", {31'b0, f}, {31'b0, (i % 4) == 0});
            if (i == 4) begin
                @(posedge clk); @(negedge clk);
                chk("R7 single cycle", {31'b0, irq}, 32'd0);
            end
        end
        rd(A_CNT, v); chk("R4 reloaded", v, 32'd3);
        wr(A_HALT, 32'd1);
    endtask

    task automatic t_free();
        logic [31:0] v;
        logic f;
        wr(A_CMP, 32'd5); wr(A_MODE, 32'd2); wr(A_GO, 32'd1);
        rd(A_CNT, v); chk("R5 clear on start", v, 32'd0);
        for (int i = 1; i <= 10; i++) begin
            do_tick(f);
            chk("R5 fire at delta", {31'b0, f}, {31'b0, i == 5});
        end
        rd(A_CNT, v); chk("R5 keeps counting", v, 32'd10);
        wr(A_HALT, 32'd1);
    endtask

    task automatic t_zero();
        logic [31:0] v;
        logic f;
        int n = 0;
        wr(A_CMP, 32'd0); wr(A_MODE, 32'd2); wr(A_GO, 32'd1);
        for (int i = 0; i < 20; i++) begin
            do_tick(f);
            if (f) n++;
        end
        chk("R6 no irq", n, 32'd0);
        rd(A_CNT, v); chk("R6 monotonic", v, 32'd20);
        wr(A_HALT, 32'd1);
    endtask

    task automatic t_shadow();
        logic [31:0] v;
        logic f;
        wr(A_CMP, 32'd3); wr(A_MODE, 32'd0); wr(A_GO, 32'd1);
        do_tick(f); do_tick(f);
        wr(A_CMP, 32'd7); wr(A_MODE, 32'd2);
        rd(A_CMP, v);  chk("R8 cmp readable", v, 32'd7);
        rd(A_MODE, v); chk("R8 ctl readable", v, 32'd2);
        for (int i = 3; i <= 8; i++) begin
            do_tick(f);
            chk("R8 old period kept", {31'b0, f}, {31'b0, (i % 4) == 0});
        end
        wr(A_HALT, 32'd1); wr(A_GO, 32'd1);
        rd(A_CNT, v); chk("R8 new mode at start", v, 32'd0);
        for (int i = 1; i <= 7; i++) begin
            do_tick(f);
            chk("R8 new cmp", {31'b0, f}, {31'b0, i == 7});
        end
    endtask

    task automatic t_hold();
        logic [31:0] v;
        logic f;
        int n = 0;
        wr(A_HALT, 32'd1);
        for (int i = 0; i < 5; i++) begin
            do_tick(f);
            if (f) n++;
        end
        chk("R9 no irq stopped", n, 32'd0);
        chk("R7 no irq stopped", {31'b0, irq}, 32'd0);
        rd(A_CNT, v);  chk("R9 counter held", v, 32'd7);
        rd(A_STAT, v); chk("R9 status", v, 32'd0);
    endtask

    task automatic t_readonly();
        logic [31:0] v;
        logic f;
        wr(A_GO, 32'd1);
        do_tick(f); do_tick(f);
        wr(A_CNT, 32'hDEAD);
        rd(A_CNT, v);  chk("R10 cnt write ignored", v, 32'd2);
        wr(A_STAT, 32'd0);
        rd(A_STAT, v); chk("R10 status write ignored", v, 32'd1);
        rd(A_GO, v);   chk("R10 start reads 0", v, 32'd0);
        rd(A_HALT, v); chk("R10 stop reads 0", v, 32'd0);
        wr(A_HALT, 32'd1);
    endtask

    task automatic t_range();
        logic [31:0] v;
        logic f;
        int n = 0;
        wr(A_CMP, 32'hFFFF_FFFF); wr(A_MODE, 32'd0); wr(A_GO, 32'd1);
        rd(A_CNT, v); chk("R11 max load", v, 32'hFFFF_FFFF);
        for (int i = 0; i < 3; i++) begin
            do_tick(f);
            if (f) n++;
        end
        chk("R11 max no irq", n, 32'd0);
        rd(A_CNT, v); chk("R11 max count", v, 32'hFFFF_FFFC);
        wr(A_HALT, 32'd1);
        wr(A_CMP, 32'hF); wr(A_MODE, 32'd2); wr(A_GO, 32'd1);
        for (int i = 1; i <= 16; i++) begin
            do_tick(f);
            chk("R11 min delta", {31'b0, f}, {31'b0, i == 15});
        end
        wr(A_HALT, 32'd1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_trigger();
        t_interval();
        t_free();
        t_zero();
        t_shadow();
        t_hold();
        t_readonly();
        t_range();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule